// File: doc/BRIEF.md
# PWM Trap Shutdown Controller

This block forces a multi-channel PWM output stage into a safe condition when an emergency is raised. A trap request comes from an active-low external pin, after a two-flop synchronizer, or from a one-cycle software set pulse. Either source raises the trap flag and the trap state on the same clock edge. While the trap state is active, each gated channel is driven to its programmed passive level. A separate auxiliary PWM signal from the second timer can be gated the same way, or left running.

The flag is cleared in one of two ways. In hardware mode it clears as soon as the synchronized pin is inactive. In software mode it clears only on a software clear pulse. Once the flag is low, the trap state waits for the selected exit event before normal operation resumes. The exit event is a zero-match of the first timer counting up, a zero-match of the second timer, or no wait at all.

The control fields are loaded through a single-cycle write strobe.

The controller is one state machine with three states:
- **RUN**: no trap.
- **FLAGGED**: the flag is 1 and the trap state is 1.
- **HOLD**: the flag is 0, the trap state is 1, and the exit event is awaited.

Its transitions are:
- **RUN→FLAGGED** on a set request.
- **FLAGGED→HOLD** on the clear condition with no set request.
- **HOLD→FLAGGED** on a set request.
- **HOLD→RUN** on the selected exit event.

Top module: `pwm_trap_ctrl`

## Requirements
- R1: After reset, trap_flag and trap_state are 0, all enables are 0, and pwm_out equals pwm_in and aux_pwm_out equals aux_pwm_in.
- R2: With cfg_pin_en=1, a low level on trap_pin_n raises trap_flag and trap_state on the third rising edge after the pin falls (two synchronizer flops, then the state register). No earlier.
- R3: With cfg_pin_en=0, a low trap_pin_n has no effect on trap_flag or trap_state.
- R4: A one-cycle sw_set pulse raises trap_flag and trap_state on the next rising edge, whatever cfg_pin_en is.
- R5: With cfg_sw_clear=0 (hardware clearing), trap_flag falls on the first edge at which the synchronized pin is high and no set request is present. trap_state stays 1.
- R6: With cfg_sw_clear=1 (software clearing), trap_flag stays 1 until an sw_clr pulse. If sw_set and sw_clr arrive together, the set wins.
- R7: With cfg_exit_mode=2'b00, after the flag is 0, trap_state falls on the edge that samples t1_zero_up=1. t2_zero pulses are ignored.
- R8: With cfg_exit_mode=2'b01, after the flag is 0, trap_state falls on the edge that samples t2_zero=1. t1_zero_up pulses are ignored.
- R9: With cfg_exit_mode=2'b11, or the reserved code 2'b10, trap_state falls one edge after trap_flag falls, with no event needed.
- R10: A set request while the flag is 0 and trap_state is 1 raises trap_flag again. The exit wait then restarts only after that flag clears.
- R11: With cfg_out_en=1 and trap_state=1, pwm_out equals cfg_passive bit for bit. Otherwise pwm_out equals pwm_in.
- R12: With cfg_aux_en=1 and trap_state=1, aux_pwm_out equals cfg_aux_passive. Otherwise aux_pwm_out equals aux_pwm_in.
- R13: Exit events sampled while trap_flag is 1 do not end the trap state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads all cfg_* fields on this edge |
| cfg_exit_mode | input | 2 | 00 first timer up zero-match, 01 second timer zero-match, 1x immediate |
| cfg_sw_clear | input | 1 | 0 hardware flag clearing, 1 software flag clearing |
| cfg_out_en | input | 1 | Trap gating of the channel outputs |
| cfg_aux_en | input | 1 | Trap gating of the auxiliary output |
| cfg_pin_en | input | 1 | Lets the pin raise a trap |
| cfg_passive | input | NUM_CH | Passive level per channel |
| cfg_aux_passive | input | 1 | Passive level of the auxiliary output |
| sw_set | input | 1 | Software set pulse of the trap flag |
| sw_clr | input | 1 | Software clear pulse of the trap flag |
| trap_pin_n | input | 1 | Asynchronous active-low trap pin |
| pwm_in | input | NUM_CH | Raw PWM channel signals |
| aux_pwm_in | input | 1 | Raw PWM signal of the second timer |
| t1_zero_up | input | 1 | First timer zero-match pulse while counting up |
| t2_zero | input | 1 | Second timer zero-match pulse |
| pwm_out | output | NUM_CH | Gated PWM channel signals |
| aux_pwm_out | output | 1 | Gated auxiliary PWM signal |
| trap_flag | output | 1 | Trap flag |
| trap_state | output | 1 | Trap state |

## Verification
The bench builds the block with NUM_CH=4 and SYNC_STAGES=2. Four channels are enough for the passive pattern and the PWM input pattern to differ in every bit position. They can therefore expose a swapped or stuck channel in the gating. Keeping two synchronizer stages places the pin-driven trap on an exact third-edge boundary, so the bench can test both one edge early and on time.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef enum logic [1:0] {
        EXIT_T1_UP = 2'b00,
        EXIT_T2    = 2'b01,
        EXIT_RSVD  = 2'b10,
        EXIT_NOW   = 2'b11
    } exit_mode_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'b00,
        ST_FLAGGED = 2'b01,
        ST_HOLD    = 2'b10
    } trap_st_e;

    typedef struct packed {
        exit_mode_e exit_mode;
        logic       sw_clear;
        logic       out_en;
        logic       aux_en;
        logic       pin_en;
    } trap_cfg_t;
endpackage

// File: rtl/trap_cfg_regs.sv
module trap_cfg_regs
    import trap_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  trap_cfg_t         cfg_d,
    input  logic [NUM_CH-1:0] passive_d,
    input  logic              aux_passive_d,
    output trap_cfg_t         cfg_q,
    output logic [NUM_CH-1:0] passive_q,
    output logic              aux_passive_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q         <= '{exit_mode: EXIT_T1_UP, default: 1'b0};
            passive_q     <= '0;
            aux_passive_q <= 1'b0;
        end else if (we) begin
            cfg_q         <= cfg_d;
            passive_q     <= passive_d;
            aux_passive_q <= aux_passive_d;
        end
    end
endmodule

// File: rtl/trap_sync.sv
module trap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= 1'b1;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
    import trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  exit_mode_e exit_mode,
    input  logic       sw_clear_mode,
    input  logic       set_req,
    input  logic       sw_clr,
    input  logic       pin_idle,
    input  logic       t1_zero_up,
    input  logic       t2_zero,
    output logic       trap_flag,
    output logic       trap_state
);
    trap_st_e st_q, st_d;
    logic     clr_cond;
    logic     exit_hit;

    always_comb begin
        clr_cond = sw_clear_mode ? sw_clr : pin_idle;
        unique case (exit_mode)
            EXIT_T1_UP: exit_hit = t1_zero_up;
            EXIT_T2:    exit_hit = t2_zero;
            default:    exit_hit = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (set_req) st_d = ST_FLAGGED;
            end
            ST_FLAGGED: begin
                if (!set_req && clr_cond) st_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (set_req)       st_d = ST_FLAGGED;
                else if (exit_hit) st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_comb begin
        trap_flag  = (st_q == ST_FLAGGED);
        trap_state = (st_q != ST_RUN);
    end
endmodule

// File: rtl/trap_gate.sv
module trap_gate #(
    parameter int NUM_CH = 6
) (
    input  logic              trap_state,
    input  logic              out_en,
    input  logic              aux_en,
    input  logic [NUM_CH-1:0] passive,
    input  logic              aux_passive,
    input  logic [NUM_CH-1:0] pwm_in,
    input  logic              aux_in,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              aux_out
);
    logic force_ch;
    assign force_ch = out_en & trap_state;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign pwm_out[c] = force_ch ? passive[c] : pwm_in[c];
        end
    endgenerate

    assign aux_out = (aux_en & trap_state) ? aux_passive : aux_in;
endmodule

// File: rtl/pwm_trap_ctrl.sv
module pwm_trap_ctrl
    import trap_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_exit_mode,
    input  logic              cfg_sw_clear,
    input  logic              cfg_out_en,
    input  logic              cfg_aux_en,
    input  logic              cfg_pin_en,
    input  logic [NUM_CH-1:0] cfg_passive,
    input  logic              cfg_aux_passive,
    input  logic              sw_set,
    input  logic              sw_clr,
    input  logic              trap_pin_n,
    input  logic [NUM_CH-1:0] pwm_in,
    input  logic              aux_pwm_in,
    input  logic              t1_zero_up,
    input  logic              t2_zero,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              aux_pwm_out,
    output logic              trap_flag,
    output logic              trap_state
);
    trap_cfg_t         cfg_d, cfg_q;
    logic [NUM_CH-1:0] passive_q;
    logic              aux_passive_q;
    logic              pin_s;
    logic              pin_act;
    logic              set_req;

    assign cfg_d = '{exit_mode: exit_mode_e'(cfg_exit_mode),
                     sw_clear:  cfg_sw_clear,
                     out_en:    cfg_out_en,
                     aux_en:    cfg_aux_en,
                     pin_en:    cfg_pin_en};

    trap_cfg_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .we            (cfg_we),
        .cfg_d         (cfg_d),
        .passive_d     (cfg_passive),
        .aux_passive_d (cfg_aux_passive),
        .cfg_q         (cfg_q),
        .passive_q     (passive_q),
        .aux_passive_q (aux_passive_q)
    );

    trap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trap_pin_n),
        .dout  (pin_s)
    );

    assign pin_act = cfg_q.pin_en & ~pin_s;
    assign set_req = pin_act | sw_set;

    trap_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .exit_mode     (cfg_q.exit_mode),
        .sw_clear_mode (cfg_q.sw_clear),
        .set_req       (set_req),
        .sw_clr        (sw_clr),
        .pin_idle      (pin_s),
        .t1_zero_up    (t1_zero_up),
        .t2_zero       (t2_zero),
        .trap_flag     (trap_flag),
        .trap_state    (trap_state)
    );

    trap_gate #(.NUM_CH(NUM_CH)) u_gate (
        .trap_state  (trap_state),
        .out_en      (cfg_q.out_en),
        .aux_en      (cfg_q.aux_en),
        .passive     (passive_q),
        .aux_passive (aux_passive_q),
        .pwm_in      (pwm_in),
        .aux_in      (aux_pwm_in),
        .pwm_out     (pwm_out),
        .aux_out     (aux_pwm_out)
    );
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
    parameter int NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_set,
    input logic              sw_clr,
    input logic              sw_mode,
    input logic [1:0]        exit_mode,
    input logic              pin_act,
    input logic              out_en,
    input logic              aux_en,
    input logic [NUM_CH-1:0] passive,
    input logic              aux_passive,
    input logic [NUM_CH-1:0] pwm_out,
    input logic              aux_out,
    input logic              trap_flag,
    input logic              trap_state,
    input logic              t1_zero_up
);
    a_r1_flag_implies_state: assert property (@(posedge clk) disable iff (!rst_n)
        trap_flag |-> trap_state);

    a_r4_sw_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> (trap_flag && trap_state));

    a_r6_sw_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode && trap_flag && !sw_clr) |=> trap_flag);

    a_r7_wait_t1: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_mode == 2'b00 && trap_state && !trap_flag && !t1_zero_up) |=> trap_state);

    a_r9_immediate_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_mode[1] && trap_state && !trap_flag && !pin_act && !sw_set) |=> !trap_state);

    a_r11_passive_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && trap_state) |-> (pwm_out == passive));

    a_r12_aux_passive: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_en && trap_state) |-> (aux_out == aux_passive));
endmodule

bind pwm_trap_ctrl trap_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_set      (sw_set),
    .sw_clr      (sw_clr),
    .sw_mode     (cfg_q.sw_clear),
    .exit_mode   (cfg_q.exit_mode),
    .pin_act     (pin_act),
    .out_en      (cfg_q.out_en),
    .aux_en      (cfg_q.aux_en),
    .passive     (passive_q),
    .aux_passive (aux_passive_q),
    .pwm_out     (pwm_out),
    .aux_out     (aux_pwm_out),
    .trap_flag   (trap_flag),
    .trap_state  (trap_state),
    .t1_zero_up  (t1_zero_up)
);

// File: tb/test_pwm_trap_ctrl.sv
`timescale 1ns/1ps
module test_pwm_trap_ctrl;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_exit_mode = 2'b00;
    logic         cfg_sw_clear = 1'b0, cfg_out_en = 1'b0, cfg_aux_en = 1'b0, cfg_pin_en = 1'b0;
    logic [N-1:0] cfg_passive = '0;
    logic         cfg_aux_passive = 1'b0;
    logic         sw_set = 1'b0, sw_clr = 1'b0, trap_pin_n = 1'b1;
    logic [N-1:0] pwm_in = 4'b0101;
    logic         aux_pwm_in = 1'b0, t1_zero_up = 1'b0, t2_zero = 1'b0;
    logic [N-1:0] pwm_out;
    logic         aux_pwm_out, trap_flag, trap_state;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    pwm_trap_ctrl #(.NUM_CH(N), .SYNC_STAGES(2)) i_pwm_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_exit_mode(cfg_exit_mode),
        .cfg_sw_clear(cfg_sw_clear), .cfg_out_en(cfg_out_en), .cfg_aux_en(cfg_aux_en),
        .cfg_pin_en(cfg_pin_en), .cfg_passive(cfg_passive), .cfg_aux_passive(cfg_aux_passive),
        .sw_set(sw_set), .sw_clr(sw_clr), .trap_pin_n(trap_pin_n), .pwm_in(pwm_in),
        .aux_pwm_in(aux_pwm_in), .t1_zero_up(t1_zero_up), .t2_zero(t2_zero),
        .pwm_out(pwm_out), .aux_pwm_out(aux_pwm_out), .trap_flag(trap_flag),
        .trap_state(trap_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic cfg(input logic [1:0] em, input logic swm, input logic oen,
                       input logic aen, input logic pen, input logic [N-1:0] pas,
                       input logic apas);
        cfg_we = 1'b1; cfg_exit_mode = em; cfg_sw_clear = swm; cfg_out_en = oen;
        cfg_aux_en = aen; cfg_pin_en = pen; cfg_passive = pas; cfg_aux_passive = apas;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_set(); sw_set = 1'b1; step(); sw_set = 1'b0; endtask
    task automatic pulse_clr(); sw_clr = 1'b1; step(); sw_clr = 1'b0; endtask
    task automatic pulse_t1();  t1_zero_up = 1'b1; step(); t1_zero_up = 1'b0; endtask
    task automatic pulse_t2();  t2_zero = 1'b1; step(); t2_zero = 1'b0; endtask

    task automatic t_reset();
        chk("R1 flag", trap_flag, 0);
        chk("R1 state", trap_state, 0);
        chk("R1 pwm pass", pwm_out, pwm_in);
        chk("R1 aux pass", aux_pwm_out, aux_pwm_in);
    endtask

    task automatic t_pin_disabled();
        cfg(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1010, 1'b1);
        trap_pin_n = 1'b0;
        step(5);
        chk("R3 flag", trap_flag, 0);
        chk("R3 state", trap_state, 0);
        trap_pin_n = 1'b1;
        step(3);
    endtask

    task automatic t_pin_hw_t1();
        cfg(2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1010, 1'b1);
        aux_pwm_in = 1'b0;
        trap_pin_n = 1'b0;
        step(2);
        chk("R2 not early", trap_flag, 0);
        step();
        chk("R2 flag", trap_flag, 1);
        chk("R2 state", trap_state, 1);
        chk("R11 passive", pwm_out, 4'b1010);
        chk("R12 aux runs", aux_pwm_out, 1'b0);
        pulse_t1();
        chk("R13 event while flagged", trap_state, 1);
        trap_pin_n = 1'b1;
        step(2);
        chk("R5 still flagged", trap_flag, 1);
        step();
        chk("R5 hw clear", trap_flag, 0);
        chk("R5 state held", trap_state, 1);
        pulse_t2();
        chk("R7 t2 ignored", trap_state, 1);
        pulse_t1();
        chk("R7 t1 exit", trap_state, 0);
        chk("R11 pass again", pwm_out, 4'b0101);
    endtask

    task automatic t_sw_t2();
        cfg(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0011, 1'b1);
        pulse_set();
        chk("R4 flag", trap_flag, 1);
        chk("R4 state", trap_state, 1);
        chk("R12 aux passive", aux_pwm_out, 1'b1);
        chk("R11 passive 0011", pwm_out, 4'b0011);
        step(3);
        chk("R6 sw hold", trap_flag, 1);
        pulse_t2();
        chk("R13 t2 while flagged", trap_state, 1);
        sw_set = 1'b1; sw_clr = 1'b1; step(); sw_set = 1'b0; sw_clr = 1'b0;
        chk("R6 set wins", trap_flag, 1);
        pulse_clr();
        chk("R6 sw clear", trap_flag, 0);
        chk("R6 state held", trap_state, 1);
        pulse_t1();
        chk("R8 t1 ignored", trap_state, 1);
        pulse_t2();
        chk("R8 t2 exit", trap_state, 0);
    endtask

    task automatic t_immediate(input logic [1:0] em, input string tag);
        cfg(em, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0);
        pulse_set();
        chk({tag, " flag"}, trap_flag, 1);
        step();
        chk({tag, " flag hw cleared"}, trap_flag, 0);
        chk({tag, " state one edge"}, trap_state, 1);
        step();
        chk({tag, " state exit"}, trap_state, 0);
    endtask

    task automatic t_reenter();
        cfg(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0110, 1'b0);
        pulse_set();
        pulse_clr();
        chk("R10 hold", trap_flag, 0);
        pulse_set();
        chk("R10 reflag", trap_flag, 1);
        pulse_t1();
        chk("R10 no exit while flagged", trap_state, 1);
        pulse_clr();
        pulse_t1();
        chk("R10 exit", trap_state, 0);
    endtask

    task automatic t_gate_off();
        cfg(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1010, 1'b1);
        pwm_in = 4'b1100; aux_pwm_in = 1'b0;
        pulse_set();
        chk("R11 disabled follows", pwm_out, 4'b1100);
        chk("R12 disabled follows", aux_pwm_out, 1'b0);
        pulse_clr();
        pulse_t1();
        chk("R11 exit", trap_state, 0);
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step();
        t_reset();
        t_pin_disabled();
        t_pin_hw_t1();
        t_sw_t2();
        t_immediate(2'b11, "R9 code11");
        t_immediate(2'b10, "R9 code10");
        t_reenter();
        t_gate_off();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule